// File: doc/BRIEF.md
# Two-Wire Polling Slave Front End

This block is the receive side of a two-wire serial slave that sits in front of a register-controlled device. It oversamples and synchronises the clock and data lines and finds start and stop conditions. It shifts in bytes MSB first. The first byte after a start is an address byte. The block acknowledges that byte only when its upper nibble is the fixed type code and its lower nibble equals the four strap inputs. The byte after the address is a command byte, and one optional data byte may follow it. The block acknowledges both and presents each to the register block with a single-cycle strobe.

A stop condition can close a transaction whose command carries the nonvolatile-write opcode. That stop starts an internal write-cycle timer, and the timer raises a busy flag. While the flag is high the block withholds the acknowledge of its own address. A master can therefore send repeated start-plus-address polls until one is acknowledged, and then carry on with its next operation.

Top module: `tw_poll_slave`

## Requirements
- R1: After reset, `sda_oe`, `nv_busy`, `cmd_valid` and `data_valid` are all 0.
- R2: An address byte is acknowledged only when bits 7:4 equal 4'b0101 and bits 3:0 equal `addr_strap`. A non-matching address is not acknowledged. No later byte before the next start is acknowledged or strobed.
- R3: The byte after an acknowledged address is acknowledged. It appears on `cmd_byte` with `cmd_valid` high for exactly one clock.
- R4: The first byte after the command is acknowledged. It appears on `data_byte` with `data_valid` high for one clock. Further bytes in the same transaction get no acknowledge and no strobe.
- R5: A stop condition after a command whose bits 7:4 equal NV_OPCODE (default 4'b1100) raises `nv_busy` for exactly WR_CYCLES clocks. A stop after any other command leaves `nv_busy` at 0.
- R6: While `nv_busy` is high, a matching address byte is not acknowledged. After `nv_busy` falls, the same address is acknowledged again.
- R7: A start condition in the middle of a byte discards the partial byte and restarts address reception.
- R8: The acknowledge is driven (`sda_oe` = 1) from the SCL falling edge after bit 8 until the next SCL falling edge. `sda_oe` is 0 while data bits are being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_strap | input | 4 | Pin-strapped low nibble of the device address |
| sda_oe | output | 1 | When 1, pull the data line low (acknowledge) |
| cmd_byte | output | 8 | Last received command byte |
| cmd_valid | output | 1 | One-clock strobe for a new command byte |
| data_byte | output | 8 | Last received data byte |
| data_valid | output | 1 | One-clock strobe for a new data byte |
| nv_busy | output | 1 | Nonvolatile write cycle in progress |

## Verification
Two functions meet on the same address byte: the busy gate from the write timer and the address comparison. The bench provokes this by sending an address poll immediately after the stop that starts a nonvolatile write. It then keeps polling until an acknowledge returns. Each poll is judged by whether `nv_busy` is high when the acknowledge bit is sampled: a busy poll must be refused, and the first poll after busy clears must be accepted and must lead to a working command byte.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam logic [3:0] TYPE_CODE = 4'b0101;
    localparam int         BYTE_BITS = 8;
    localparam int         BCNT_W    = $clog2(BYTE_BITS + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
        logic scl;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [7:0] a, input logic [3:0] strap);
        return (a[7:4] == TYPE_CODE) && (a[3:0] == strap);
    endfunction

    function automatic logic is_nv_cmd(input logic [7:0] c, input logic [3:0] op);
        return c[7:4] == op;
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din[g]};
            end
            assign dout[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
    import tw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
        ev.scl      = scl_s;
    end
endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
    import tw_pkg::*;
#(
    parameter logic [3:0] NV_OPCODE = 4'b1100
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [3:0] strap,
    input  logic       busy,
    output logic       ack_on,
    output logic [7:0] cmd_byte,
    output logic       cmd_valid,
    output logic [7:0] data_byte,
    output logic       data_valid,
    output logic       launch
);
    phase_e            phase;
    logic [BCNT_W-1:0] bitcnt;
    logic [7:0]        shreg;
    logic              nv_seen;
    logic              receiving;
    logic              byte_full;

    assign receiving = (phase == PH_ADDR) || (phase == PH_CMD) || (phase == PH_DATA);
    assign byte_full = (bitcnt == BCNT_W'(BYTE_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            nv_seen    <= 1'b0;
            ack_on     <= 1'b0;
            cmd_byte   <= '0;
            cmd_valid  <= 1'b0;
            data_byte  <= '0;
            data_valid <= 1'b0;
            launch     <= 1'b0;
        end else begin
            cmd_valid  <= 1'b0;
            data_valid <= 1'b0;
            launch     <= 1'b0;
            if (ev.start) begin
                phase   <= PH_ADDR;
                bitcnt  <= '0;
                ack_on  <= 1'b0;
                nv_seen <= 1'b0;
            end else if (ev.stop) begin
                launch  <= nv_seen;
                nv_seen <= 1'b0;
                phase   <= PH_IDLE;
                ack_on  <= 1'b0;
                bitcnt  <= '0;
            end else if (ev.scl_rise) begin
                if (receiving && !byte_full && !ack_on) begin
                    shreg  <= {shreg[6:0], ev.sda};
                    bitcnt <= bitcnt + 1'b1;
                end
            end else if (ev.scl_fall) begin
                if (ack_on) begin
                    ack_on <= 1'b0;
                    bitcnt <= '0;
                end else if (byte_full) begin
                    unique case (phase)
                        PH_ADDR: begin
                            if (addr_hit(shreg, strap) && !busy) begin
                                ack_on <= 1'b1;
                                phase  <= PH_CMD;
                            end else begin
                                phase  <= PH_SKIP;
                            end
                        end
                        PH_CMD: begin
                            ack_on    <= 1'b1;
                            cmd_byte  <= shreg;
                            cmd_valid <= 1'b1;
                            nv_seen   <= is_nv_cmd(shreg, NV_OPCODE);
                            phase     <= PH_DATA;
                        end
                        PH_DATA: begin
                            ack_on     <= 1'b1;
                            data_byte  <= shreg;
                            data_valid <= 1'b1;
                            phase      <= PH_SKIP;
                        end
                        default: phase <= PH_SKIP;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/tw_write_timer.sv
module tw_write_timer #(
    parameter int WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                          remain <= '0;
        else if (launch && remain == '0)  remain <= CNT_W'(WR_CYCLES);
        else if (remain != '0)            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/tw_poll_slave.sv
module tw_poll_slave
    import tw_pkg::*;
#(
    parameter int         WR_CYCLES   = 500000,
    parameter logic [3:0] NV_OPCODE   = 4'b1100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [3:0] addr_strap,
    output logic       sda_oe,
    output logic [7:0] cmd_byte,
    output logic       cmd_valid,
    output logic [7:0] data_byte,
    output logic       data_valid,
    output logic       nv_busy
);
    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    bus_ev_t    ev;
    logic       launch;

    tw_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({scl_i, sda_i}),
        .dout(lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    tw_cond_detect u_cond (
        .clk  (clk),
        .rst  (rst),
        .scl_s(scl_s),
        .sda_s(sda_s),
        .ev   (ev)
    );

    tw_slave_fsm #(.NV_OPCODE(NV_OPCODE)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap     (addr_strap),
        .busy      (nv_busy),
        .ack_on    (sda_oe),
        .cmd_byte  (cmd_byte),
        .cmd_valid (cmd_valid),
        .data_byte (data_byte),
        .data_valid(data_valid),
        .launch    (launch)
    );

    tw_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .launch(launch),
        .busy  (nv_busy)
    );
endmodule

// File: rtl/tw_poll_slave_chk.sv
module tw_poll_slave_chk #(
    parameter int WR_CYCLES = 500000
) (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic sda_oe,
    input logic cmd_valid,
    input logic data_valid,
    input logic nv_busy
);
    localparam int CNT_W = $clog2(WR_CYCLES + 2);

    logic [CNT_W-1:0] busy_len;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= '0;
            busy_q   <= 1'b0;
        end else begin
            busy_q   <= nv_busy;
            busy_len <= nv_busy ? busy_len + 1'b1 : '0;
        end
    end

    // R8
    ack_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R8
    ack_release_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> !scl_s);

    // R3
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R4
    data_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && data_valid));

    // R6
    no_cmd_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !nv_busy);

    // R5
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !nv_busy) |-> (busy_len == CNT_W'(WR_CYCLES)));
endmodule

bind tw_poll_slave tw_poll_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .cmd_valid (cmd_valid),
    .data_valid(data_valid),
    .nv_busy   (nv_busy)
);

// File: tb/tw_poll_slave_tb.sv
module tw_poll_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WRC        = 1500;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mscl = 1'b1;
    logic       msda = 1'b1;
    logic [3:0] strap = 4'hA;
    logic       sda_oe, cmd_valid, data_valid, nv_busy;
    logic [7:0] cmd_byte, data_byte;
    wire        sda_bus = msda & ~sda_oe;

    int ntests = 0;
    int nfail  = 0;
    logic [8:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_poll_slave #(.WR_CYCLES(WRC), .NV_OPCODE(4'b1100)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (mscl),
        .sda_i     (sda_bus),
        .addr_strap(strap),
        .sda_oe    (sda_oe),
        .cmd_byte  (cmd_byte),
        .cmd_valid (cmd_valid),
        .data_byte (data_byte),
        .data_valid(data_valid),
        .nv_busy   (nv_busy)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    endtask

    // scoreboard monitor: bit 8 marks data (1) or command (0)
    always @(negedge clk) begin
        if (!rst && (cmd_valid || data_valid)) begin
            logic [8:0] got;
            got = data_valid ? {1'b1, data_byte} : {1'b0, cmd_byte};
            if (expq.size() == 0) begin
                check("R2/R4 unexpected strobe", int'(got), -1);
            end else begin
                logic [8:0] want;
                want = expq.pop_front();
                check(want[8] ? "R4 data byte" : "R3 command byte", int'(got), int'(want));
            end
        end
    end

    task automatic bus_start();
        msda = 1'b1; tick(Q);
        mscl = 1'b1; tick(Q);
        msda = 1'b0; tick(Q);
        mscl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        msda = 1'b0; tick(Q);
        mscl = 1'b1; tick(Q);
        msda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            msda = b[i]; tick(Q);
            mscl = 1'b1; tick(Q);
            check("R8 released during data bit", int'(sda_oe), 0);
            tick(Q);
            mscl = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, output logic busy_at_ack);
        send_bits(b, 8);
        msda = 1'b1; tick(Q);
        mscl = 1'b1; tick(Q);
        acked = sda_oe && (sda_bus == 1'b0);
        busy_at_ack = nv_busy;
        tick(Q);
        mscl = 1'b0; tick(Q);
        if (acked) check("R8 ack released after falling edge", int'(sda_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic ak, bz;
        int   cnt, polls;
        tick(4);
        rst = 1'b0;
        tick(2);
        // R1
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 nv_busy", int'(nv_busy), 0);
        check("R1 strobes", int'(cmd_valid | data_valid), 0);

        // R2, R3, R4: full transaction with a non-write command
        bus_start();
        send_byte(8'h5A, ak, bz); check("R2 matching address ack", int'(ak), 1);
        expq.push_back({1'b0, 8'h3C});
        send_byte(8'h3C, ak, bz); check("R3 command ack", int'(ak), 1);
        expq.push_back({1'b1, 8'h81});
        send_byte(8'h81, ak, bz); check("R4 data ack", int'(ak), 1);
        send_byte(8'h77, ak, bz); check("R4 extra byte no ack", int'(ak), 0);
        bus_stop();
        tick(20);
        check("R5 non-write command leaves busy low", int'(nv_busy), 0);

        // R2: wrong type nibble, then the following byte must be ignored
        bus_start();
        send_byte(8'h4A, ak, bz); check("R2 wrong type nibble", int'(ak), 0);
        send_byte(8'h3C, ak, bz); check("R2 byte after mismatch ignored", int'(ak), 0);
        bus_stop();
        // R2: wrong strap bit
        bus_start();
        send_byte(8'h5B, ak, bz); check("R2 wrong strap nibble", int'(ak), 0);
        bus_stop();
        strap = 4'h3;
        tick(4);
        bus_start();
        send_byte(8'h53, ak, bz); check("R2 other strap value", int'(ak), 1);
        bus_stop();
        strap = 4'hA;
        tick(4);

        // R7: repeated start in the middle of a command byte
        bus_start();
        send_byte(8'h5A, ak, bz); check("R7 first address ack", int'(ak), 1);
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(8'h5A, ak, bz); check("R7 address after restart", int'(ak), 1);
        expq.push_back({1'b0, 8'h12});
        send_byte(8'h12, ak, bz); check("R7 command after restart", int'(ak), 1);
        bus_stop();
        tick(20);

        // R5, R6: nonvolatile write then address polling
        bus_start();
        send_byte(8'h5A, ak, bz);
        expq.push_back({1'b0, 8'hC3});
        send_byte(8'hC3, ak, bz); check("R3 write command ack", int'(ak), 1);
        expq.push_back({1'b1, 8'h2F});
        send_byte(8'h2F, ak, bz);
        bus_stop();
        tick(4);
        check("R5 busy after write stop", int'(nv_busy), 1);
        polls = 0;
        ak = 1'b0;
        while (!ak && polls < 20) begin
            bus_start();
            send_byte(8'h5A, ak, bz);
            polls++;
            if (ak) check("R6 ack only when not busy", int'(bz), 0);
            else begin
                check("R6 nack while busy", int'(bz), 1);
                bus_stop();
            end
        end
        check("R6 poll eventually acked", int'(ak), 1);
        check("R6 first poll refused", int'(polls > 1), 1);
        expq.push_back({1'b0, 8'h05});
        send_byte(8'h05, ak, bz); check("R6 command after poll", int'(ak), 1);
        bus_stop();
        tick(20);

        // R5: exact busy length
        bus_start();
        send_byte(8'h5A, ak, bz);
        expq.push_back({1'b0, 8'hCF});
        send_byte(8'hCF, ak, bz);
        msda = 1'b0; tick(Q);
        mscl = 1'b1; tick(Q);
        msda = 1'b1;
        cnt = 0;
        while (!nv_busy && cnt < 50) begin cnt++; tick(1); end
        cnt = 0;
        while (nv_busy && cnt < 3 * WRC) begin cnt++; tick(1); end
        check("R5 busy length", cnt, WRC);
        tick(10);
        check("R3/R4 scoreboard drained", expq.size(), 0);
        finish_run();
    end
endmodule